// File: doc/BRIEF.md
# Interrupt Descriptor Queue Writer

This block gathers interrupt events raised by the bit-level serial processing logic. For each event that is not masked, it writes a one-dword descriptor into a circular queue in shared host memory. The writes go through a bus-master write port that uses a valid/ready handshake. Accepted events first wait in a small internal FIFO, so a stalled write port does not lose them at once. If the FIFO fills, further events are dropped and a sticky flag records the loss.

The queue geometry comes from a two-dword queue descriptor. The dword at byte offset 0 holds the base address. The dword at byte offset 4 holds a 15-bit length field that counts from zero. The host can load the geometry in two ways:
- It can write either dword directly through a register port.
- It can raise a service request that points at a copy of the descriptor in memory. The block then fetches both dwords through a bus-master read port.

Every load sends the write pointer back to the base address. While a fetch is running, no queue write is presented. Events that arrive during the fetch stay in the FIFO and are written once the new geometry is in place.

Top module: `irq_desc_queue_writer`

## Requirements
- R1: After reset, `wr_valid`, `rd_req_valid`, `fetch_busy`, `cfg_err` and `evt_overflow` are low. The geometry is base 0 with a length field of 1.
- R2: A direct write with `cfg_wr_sel`=0 loads the base address from `cfg_wr_data` with bits 1:0 forced to zero. The next queue write goes to that base.
- R3: A direct write with `cfg_wr_sel`=1 loads the length field from bits 14:0 and ignores bits 31:15. The queue then holds field+1 entries, and the next queue write goes to the base.
- R4: Successive queue writes go to base, base+4, base+8 and so on. The write after entry index equal to the length field returns to the base.
- R5: A length field of 0 is handled as 1, giving two entries, and sets `cfg_err`. A later load with a nonzero field clears `cfg_err`.
- R6: An event whose type has its bit set in `evt_mask` (bit index = `evt_type`) produces no queue write.
- R7: Accepted events are written in arrival order. Up to 8 are held while the write port stalls. An event arriving while 8 are held is dropped and sets `evt_overflow`, which stays set until reset.
- R8: A pulse on `svc_req` while idle makes the block read `svc_desc_addr` with bits 1:0 cleared, then that address +4. The first returned dword loads the base (bits 1:0 cleared). The second loads the length as in R3 and R5. `fetch_busy` is high from the request until the second dword is loaded.
- R9: While the descriptor reads are in progress, `wr_valid` stays low. Events that arrive meanwhile are written afterwards, starting at the newly fetched base.
- R10: Once `wr_valid` is high with `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` hold until the transfer is accepted, unless a direct register write changes the geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Direct geometry register write strobe |
| cfg_wr_sel | input | 1 | 0 selects the base dword, 1 selects the length dword |
| cfg_wr_data | input | 32 | Direct write data |
| svc_req | input | 1 | Request to fetch the descriptor from memory |
| svc_desc_addr | input | 32 | Memory address of the descriptor copy |
| evt_valid | input | 1 | An event is offered this cycle |
| evt_type | input | TYPE_W | Event type, indexes `evt_mask` |
| evt_word | input | 32 | Descriptor dword to write for the event |
| evt_mask | input | 2**TYPE_W | Per-type suppression bits |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Queue write valid |
| wr_ready | input | 1 | Queue write accepted |
| wr_addr | output | 32 | Queue write address |
| wr_data | output | 32 | Queue write data |
| fetch_busy | output | 1 | Descriptor fetch pending or running |
| cfg_err | output | 1 | Last loaded length field was zero |
| evt_overflow | output | 1 | Sticky: an event was dropped on a full FIFO |

## Verification
The queue writer is driven with several geometries:
- a three-entry queue at an unaligned base, which shows alignment and wrap;
- a zero length field, which separates the error fallback from plain use;
- a length dword with reserved bits set, which shows that the upper bits are ignored;
- a four-entry queue fetched from memory, which tells a fetched load from a direct one.

Bursts of events are applied against a stalled write port. This tells in-order buffering apart from dropping and shows that address and data hold during the stall. Masked and unmasked types are interleaved, so suppression is told apart from loss. Events are also raised during a fetch, which shows they are held back and then written at the new base.

// File: rtl/irq_qw_pkg.sv
package irq_qw_pkg;

  localparam int LEN_W = 15;

  typedef enum logic [2:0] {
    F_IDLE,
    F_PEND,
    F_RQ_PTR,
    F_WT_PTR,
    F_RQ_LEN,
    F_WT_LEN
  } fetch_state_e;

  // Zero is not a legal length field; fall back to the two-entry minimum.
  function automatic logic [LEN_W-1:0] len_fix(input logic [LEN_W-1:0] f);
    return (f == '0) ? LEN_W'(1) : f;
  endfunction

  // Entry index after a write; index equal to the last slot wraps to zero.
  function automatic logic [LEN_W-1:0] idx_next(input logic [LEN_W-1:0] idx,
                                                input logic [LEN_W-1:0] last);
    return (idx == last) ? '0 : idx + LEN_W'(1);
  endfunction

  // Byte address of an entry: base plus four bytes per entry.
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input logic [LEN_W-1:0] idx);
    return base + {{(32-LEN_W-2){1'b0}}, idx, 2'b00};
  endfunction

endpackage

// File: rtl/irq_evt_fifo.sv
module irq_evt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         push_ok,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] head
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= ptr_inc(wr_q);
      if (pop_ok)  rd_q <= ptr_inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Occupancy never exceeds the FIFO depth.
  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // A full FIFO with no pop stays full and keeps its head entry.
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(head)));

endmodule

// File: rtl/irq_desc_fetch.sv
module irq_desc_fetch
  import irq_qw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_req,
  input  logic [31:0] svc_addr,
  input  logic        start_ok,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        busy,
  output logic        active,
  output logic        ld_base,
  output logic        ld_len,
  output logic [31:0] ld_word
);

  fetch_state_e st_q, st_d;
  logic [31:0]  addr_q;

  assign busy    = (st_q != F_IDLE);
  assign active  = busy && (st_q != F_PEND);
  assign ld_base = (st_q == F_WT_PTR) && rd_rsp_valid;
  assign ld_len  = (st_q == F_WT_LEN) && rd_rsp_valid;
  assign ld_word = rd_rsp_data;

  always_comb begin
    rd_req_valid = 1'b0;
    rd_req_addr  = addr_q;
    st_d         = st_q;
    case (st_q)
      F_IDLE:   if (svc_req) st_d = F_PEND;
      F_PEND:   if (start_ok) st_d = F_RQ_PTR;
      F_RQ_PTR: begin
        rd_req_valid = 1'b1;
        if (rd_req_ready) st_d = F_WT_PTR;
      end
      F_WT_PTR: if (rd_rsp_valid) st_d = F_RQ_LEN;
      F_RQ_LEN: begin
        rd_req_valid = 1'b1;
        rd_req_addr  = addr_q + 32'd4;
        if (rd_req_ready) st_d = F_WT_LEN;
      end
      F_WT_LEN: if (rd_rsp_valid) st_d = F_IDLE;
      default:  st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == F_IDLE && svc_req) addr_q <= svc_addr & ~32'h3;
    end
  end

  // Descriptor reads are always dword aligned.
  assert_rd_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

  // A read request that is not accepted stays presented at the same address.
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

endmodule

// File: rtl/irq_queue_geom.sv
module irq_queue_geom
  import irq_qw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_ld,
  input  logic [31:0] base_word,
  input  logic        len_ld,
  input  logic [31:0] len_word,
  input  logic        advance,
  output logic [31:0] cur_addr,
  output logic        cfg_err
);

  logic [31:0]      base_q;
  logic [LEN_W-1:0] last_q;
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] len_field;

  assign len_field = len_word[LEN_W-1:0];
  assign cur_addr  = slot_addr(base_q, idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      last_q  <= LEN_W'(1);
      idx_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (base_ld) base_q <= base_word & ~32'h3;
      if (len_ld) begin
        last_q  <= len_fix(len_field);
        cfg_err <= (len_field == '0);
      end
      if (base_ld || len_ld) idx_q <= '0;
      else if (advance)      idx_q <= idx_next(idx_q, last_q);
    end
  end

  // The stored last index is never zero.
  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_q != '0);

  // The entry index never runs past the last slot.
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_q);

  // Any load restarts the pointer at the base.
  assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_ld || len_ld) |=> (cur_addr == base_q));

endmodule

// File: rtl/irq_desc_queue_writer.sv
module irq_desc_queue_writer
  import irq_qw_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TYPE_W     = 4,
  localparam int NTYPES    = 1 << TYPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [31:0]       cfg_wr_data,
  input  logic              svc_req,
  input  logic [31:0]       svc_desc_addr,
  input  logic              evt_valid,
  input  logic [TYPE_W-1:0] evt_type,
  input  logic [31:0]       evt_word,
  input  logic [NTYPES-1:0] evt_mask,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic              fetch_busy,
  output logic              cfg_err,
  output logic              evt_overflow
);

  // Named internal events.
  logic        evt_masked, evt_offer, evt_accept, evt_drop;
  logic        fifo_full, fifo_empty;
  logic        wr_fire, wr_stalled, fetch_active;
  logic        f_ld_base, f_ld_len;
  logic [31:0] f_word;
  logic        base_ld, len_ld;
  logic [31:0] base_word, len_word;

  assign evt_masked = evt_mask[evt_type];
  assign evt_offer  = evt_valid && !evt_masked;
  assign evt_drop   = evt_offer && fifo_full;

  irq_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (evt_offer),
    .push_data (evt_word),
    .pop       (wr_fire),
    .push_ok   (evt_accept),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .head      (wr_data)
  );

  assign wr_valid   = !fifo_empty && !fetch_active;
  assign wr_fire    = wr_valid && wr_ready;
  assign wr_stalled = wr_valid && !wr_ready;

  irq_desc_fetch u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .svc_req      (svc_req),
    .svc_addr     (svc_desc_addr),
    .start_ok     (!wr_stalled),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .busy         (fetch_busy),
    .active       (fetch_active),
    .ld_base      (f_ld_base),
    .ld_len       (f_ld_len),
    .ld_word      (f_word)
  );

  // A fetched dword takes priority over a direct write in the same cycle.
  assign base_ld   = f_ld_base || (cfg_wr_en && !cfg_wr_sel);
  assign len_ld    = f_ld_len  || (cfg_wr_en &&  cfg_wr_sel);
  assign base_word = f_ld_base ? f_word : cfg_wr_data;
  assign len_word  = f_ld_len  ? f_word : cfg_wr_data;

  irq_queue_geom u_geom (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_ld   (base_ld),
    .base_word (base_word),
    .len_ld    (len_ld),
    .len_word  (len_word),
    .advance   (wr_fire),
    .cur_addr  (wr_addr),
    .cfg_err   (cfg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        evt_overflow <= 1'b0;
    else if (evt_drop) evt_overflow <= 1'b1;
  end

  // A stalled write keeps its address and data until it is accepted.
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stalled && !cfg_wr_en) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // No queue write is offered while the descriptor reads are running.
  assert_no_wr_in_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !wr_valid);

  // Queue writes are always dword aligned.
  assert_wr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  // The overflow flag, once set, stays set.
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> evt_overflow);

  // A masked event is never counted as accepted.
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_masked) |-> !evt_accept);

endmodule

// File: tb/irq_desc_queue_writer_tb_top.sv
module irq_desc_queue_writer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        svc_req = 1'b0;
  logic [31:0] svc_desc_addr = '0;
  logic        evt_valid = 1'b0;
  logic [3:0]  evt_type = '0;
  logic [31:0] evt_word = '0;
  logic [15:0] evt_mask = '0;
  logic        rd_req_valid, rd_rsp_valid;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        wr_valid, wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data;
  logic        fetch_busy, cfg_err, evt_overflow;

  int n_chk = 0, n_bad = 0;
  logic [31:0] log_a [0:255];
  logic [31:0] log_d [0:255];
  int          nlog = 0;
  logic [31:0] rd_log [0:15];
  int          nrd = 0;
  logic [31:0] mem_a0 = 32'h100, mem_w0 = '0, mem_w1 = '0;

  // Independent geometry model: base, last index, current index.
  logic [31:0] m_base = '0;
  int          m_last = 1, m_idx = 0;

  always #2 clk = ~clk;

  irq_desc_queue_writer dut_i (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_sel, .cfg_wr_data, .svc_req, .svc_desc_addr,
    .evt_valid, .evt_type, .evt_word, .evt_mask, .rd_req_valid, .rd_req_ready,
    .rd_req_addr, .rd_rsp_valid, .rd_rsp_data, .wr_valid, .wr_ready, .wr_addr,
    .wr_data, .fetch_busy, .cfg_err, .evt_overflow
  );

  // Memory model: one-cycle read latency.
  always @(posedge clk) begin
    if (!rst_n) rd_rsp_valid <= 1'b0;
    else begin
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= (rd_req_addr == mem_a0) ? mem_w0 :
                      (rd_req_addr == mem_a0 + 32'd4) ? mem_w1 : 32'hDEAD_BEEF;
    end
  end

  // Transfer monitors sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && nlog < 256) begin
      log_a[nlog] = wr_addr; log_d[nlog] = wr_data; nlog++;
    end
    if (rst_n && rd_req_valid && rd_req_ready && nrd < 16) begin
      rd_log[nrd] = rd_req_addr; nrd++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic send(input logic [3:0] t, input logic [31:0] d);
    @(negedge clk); evt_valid = 1'b1; evt_type = t; evt_word = d;
    @(negedge clk); evt_valid = 1'b0;
  endtask

  function automatic logic [31:0] m_take();
    logic [31:0] a;
    a = m_base + 32'(m_idx * 4);
    m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
    return a;
  endfunction

  // Compare n logged writes from index s against the model and data pattern.
  task automatic expect_writes(input string req, input int s, input int n, input logic [31:0] d0);
    chk({req, " write count"}, 32'(nlog - s), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk({req, " addr"}, log_a[s+i], m_take());
      chk({req, " data"}, log_d[s+i], d0 + 32'(i));
    end
  endtask

  task automatic t_reset();
    chk("R1 wr_valid", {31'b0, wr_valid}, 32'd0);
    chk("R1 rd_req_valid", {31'b0, rd_req_valid}, 32'd0);
    chk("R1 fetch_busy", {31'b0, fetch_busy}, 32'd0);
    chk("R1 cfg_err", {31'b0, cfg_err}, 32'd0);
    chk("R1 overflow", {31'b0, evt_overflow}, 32'd0);
    // Reset geometry: base 0, two entries.
    begin
      int s = nlog;
      send(4'd1, 32'h0000_5000); send(4'd1, 32'h0000_5001); send(4'd1, 32'h0000_5002);
      cyc(4);
      expect_writes("R1", s, 3, 32'h0000_5000);
    end
  endtask

  task automatic t_direct_wrap();
    int s;
    cfg(1'b0, 32'h0000_1003);
    m_base = 32'h1000; m_idx = 0;
    cfg(1'b1, 32'h0000_0002);
    m_last = 2; m_idx = 0;
    s = nlog;
    for (int i = 0; i < 5; i++) send(4'd0, 32'hA000 + 32'(i));
    cyc(4);
    chk("R2 first addr aligned base", log_a[s], 32'h1000);
    expect_writes("R4", s, 5, 32'hA000);
  endtask

  task automatic t_len_zero();
    int s;
    cfg(1'b1, 32'h0000_0000);
    m_last = 1; m_idx = 0;
    cyc(1);
    chk("R5 cfg_err set", {31'b0, cfg_err}, 32'd1);
    s = nlog;
    for (int i = 0; i < 3; i++) send(4'd2, 32'hB000 + 32'(i));
    cyc(4);
    expect_writes("R5", s, 3, 32'hB000);
    cfg(1'b1, 32'hFFFF_8001);
    m_last = 1; m_idx = 0;
    cyc(1);
    chk("R5 cfg_err cleared", {31'b0, cfg_err}, 32'd0);
    s = nlog;
    for (int i = 0; i < 3; i++) send(4'd2, 32'hB100 + 32'(i));
    cyc(4);
    expect_writes("R3", s, 3, 32'hB100);
  endtask

  task automatic t_mask();
    int s;
    evt_mask = 16'h0008;
    s = nlog;
    send(4'd3, 32'hDEAD_0003);
    cyc(5);
    chk("R6 masked type writes nothing", 32'(nlog - s), 32'd0);
    chk("R6 masked type leaves wr_valid low", {31'b0, wr_valid}, 32'd0);
    send(4'd2, 32'hE000);
    cyc(4);
    expect_writes("R6", s, 1, 32'hE000);
    evt_mask = '0;
  endtask

  task automatic t_overflow();
    int s;
    logic [31:0] a0, d0;
    wr_ready = 1'b0;
    s = nlog;
    for (int i = 0; i < 10; i++) send(4'd5, 32'hC000 + 32'(i));
    a0 = wr_addr; d0 = wr_data;
    chk("R10 valid while stalled", {31'b0, wr_valid}, 32'd1);
    cyc(3);
    chk("R10 valid held", {31'b0, wr_valid}, 32'd1);
    chk("R10 addr held", wr_addr, a0);
    chk("R10 data held", wr_data, d0);
    chk("R7 no writes while stalled", 32'(nlog - s), 32'd0);
    chk("R7 overflow set", {31'b0, evt_overflow}, 32'd1);
    wr_ready = 1'b1;
    cyc(12);
    expect_writes("R7", s, 8, 32'hC000);
    chk("R7 overflow sticky", {31'b0, evt_overflow}, 32'd1);
  endtask

  task automatic t_fetch();
    int s, r, guard;
    logic busy_seen;
    mem_a0 = 32'h100; mem_w0 = 32'h0000_2002; mem_w1 = 32'h0001_0003;
    s = nlog; r = nrd;
    @(negedge clk); svc_req = 1'b1; svc_desc_addr = 32'h0000_0101;
    @(negedge clk); svc_req = 1'b0;
    busy_seen = fetch_busy;
    send(4'd7, 32'hF000); send(4'd7, 32'hF001);
    guard = 0;
    while (fetch_busy && guard < 50) begin cyc(1); guard++; end
    m_base = 32'h2000; m_last = 3; m_idx = 0;
    cyc(4);
    chk("R8 busy during fetch", {31'b0, busy_seen}, 32'd1);
    chk("R8 busy clears", {31'b0, fetch_busy}, 32'd0);
    chk("R8 read count", 32'(nrd - r), 32'd2);
    chk("R8 first read addr", rd_log[r], 32'h100);
    chk("R8 second read addr", rd_log[r+1], 32'h104);
    expect_writes("R9", s, 2, 32'hF000);
    s = nlog;
    for (int i = 0; i < 3; i++) send(4'd7, 32'hF100 + 32'(i));
    cyc(4);
    expect_writes("R8", s, 3, 32'hF100);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_direct_wrap();
    t_len_zero();
    t_mask();
    t_overflow();
    t_fetch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule